// File: doc/BRIEF.md
# Gated Frequency Counter

The block measures the frequency of a conditioned pulse train by counting its rising edges over a precisely timed gate window. A reference clock drives a prescaler followed by a chain of divide-by-ten stages. The chosen stage sets how long the main gate stays open. While the gate is open, every synchronised rising edge of the input adds one to an accumulator. When the gate closes, the accumulated value is latched as the result together with a code for the gate length. Because gate lengths step by factors of ten, the count reads directly as frequency, and the code gives the position of the decimal point.

A measurement is started in one of two ways. A start pulse opens a single gate. Holding the continuous control high runs gates back to back with no dead cycle. The result, like any gated count, is uncertain by one count. If the accumulator range is exceeded, the count saturates and an overflow flag is latched with the result.

Top module: `freq_gate_counter`

## Requirements
- R1: After reset, result_o, range_code_o, overflow_o and result_valid_o are all 0 and no gate is open.
- R2: A gate selected with code k (0 to NUM_RANGES-1) lasts exactly BASE_DIV*10^k reference cycles. The code is captured when the gate opens, a change of range_sel during the gate has no effect on that gate, and range_code_o reports the code of the latched result.
- R3: For an input of period P cycles, the latched count differs from G/P by at most one, where G is the gate length. Only rising edges are counted, so an input held high or low during the gate gives 0.
- R4: If more than 2^CNT_W-1 edges arrive in one gate, the result saturates at 2^CNT_W-1 and overflow_o is 1 for that result. A result without overflow has overflow_o 0.
- R5: With run_cont low, a start pulse sampled at clock edge E0 opens one gate, and the new result becomes visible after edge E0+G. A start pulse while a gate is open neither restarts nor extends that gate, and the block then idles.
- R6: With run_cont high, gates run back to back without any start pulse, and the result is refreshed at the end of every gate.
- R7: result_o, range_code_o and overflow_o change only when a gate closes and hold between closes. result_valid_o goes to 1 at the first gate close and stays 1 until reset.
- R8: The accumulator and the overflow state clear at the start of every gate, so no count carries from one measurement into the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference (timebase) clock |
| rst | input | 1 | Synchronous active-high reset |
| sig_in | input | 1 | Conditioned pulse train, asynchronous to clk |
| range_sel | input | RW | Gate-length code k, gate = BASE_DIV*10^k cycles |
| run_cont | input | 1 | 1 = back-to-back gates, 0 = one gate per start pulse |
| start | input | 1 | Opens one gate when idle and run_cont is 0 |
| result_o | output | CNT_W | Latched edge count of the last gate |
| range_code_o | output | RW | Gate code (decimal point position) of the latched result |
| overflow_o | output | 1 | Latched count exceeded the accumulator range |
| result_valid_o | output | 1 | At least one result has been latched since reset |

## Verification
In continuous mode, the closing cycle of one gate is also the clearing cycle of the next. The latch and the clear fall in the same clock, and an input edge may land in that cycle too. The bench provokes this by running continuous gates over many input periods and sampling the result at unaligned times. Every sample must stay within one count of G/P: a sample above that range means the clear was lost, and a sample below it means a cycle was dropped at the gate boundary. A second coincidence, a start pulse arriving mid-gate, is judged by the exact cycle at which the result changes.

// File: rtl/fcnt_pkg.sv
package fcnt_pkg;

  typedef enum logic {
    GATE_IDLE = 1'b0,
    GATE_OPEN = 1'b1
  } gate_state_e;

  function automatic int unsigned sel_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/fcnt_edge_sync.sv
module fcnt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise_o
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_in};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/fcnt_timebase.sv
module fcnt_timebase #(
  parameter int BASE_DIV   = 100,
  parameter int NUM_RANGES = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr,
  input  logic                  run,
  output logic [NUM_RANGES-1:0] tick_o
);

  localparam int PRE_W = (BASE_DIV > 2) ? $clog2(BASE_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(BASE_DIV - 1);

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pre_q <= '0;
    end else if (run) begin
      pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + PRE_W'(1);
    end
  end

  assign tick_o[0] = run & (pre_q == PRE_LAST);

  for (genvar k = 1; k < NUM_RANGES; k++) begin : g_decade
    logic [3:0] dec_q;

    always_ff @(posedge clk) begin
      if (rst || clr) begin
        dec_q <= 4'd0;
      end else if (tick_o[k-1]) begin
        dec_q <= (dec_q == 4'd9) ? 4'd0 : dec_q + 4'd1;
      end
    end

    assign tick_o[k] = tick_o[k-1] & (dec_q == 4'd9);
  end

endmodule

// File: rtl/fcnt_gate_fsm.sv
module fcnt_gate_fsm
  import fcnt_pkg::*;
#(
  parameter int NUM_RANGES = 4,
  parameter int RW         = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic                  run_cont,
  input  logic [RW-1:0]         range_sel,
  input  logic [NUM_RANGES-1:0] tick_vec,
  output logic                  gate_open,
  output logic                  gate_clr,
  output logic                  gate_close,
  output logic [RW-1:0]         range_q
);

  localparam logic [RW-1:0] TOP_CODE = RW'(NUM_RANGES - 1);

  gate_state_e   state_q, state_d;
  logic [RW-1:0] sel_clamped;

  assign sel_clamped = (range_sel > TOP_CODE) ? TOP_CODE : range_sel;
  assign gate_open   = (state_q == GATE_OPEN);
  assign gate_close  = gate_open & tick_vec[range_q];
  assign gate_clr    = (!gate_open & (start | run_cont)) | (gate_close & run_cont);

  always_comb begin
    state_d = state_q;
    case (state_q)
      GATE_IDLE: if (start || run_cont) state_d = GATE_OPEN;
      GATE_OPEN: if (gate_close)        state_d = run_cont ? GATE_OPEN : GATE_IDLE;
      default:                          state_d = GATE_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= GATE_IDLE;
      range_q <= '0;
    end else begin
      state_q <= state_d;
      if (gate_clr) range_q <= sel_clamped;
    end
  end

endmodule

// File: rtl/fcnt_accum.sv
module fcnt_accum #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic             pulse,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] sum_o,
  output logic             ovf_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic ovf_q;
  logic hit_max;

  assign hit_max = pulse & (cnt_q == CNT_MAX);
  assign sum_o   = hit_max ? CNT_MAX : cnt_q + CNT_W'(pulse);
  assign ovf_o   = ovf_q | hit_max;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (en) begin
      cnt_q <= sum_o;
      ovf_q <= ovf_o;
    end
  end

endmodule

// File: rtl/freq_gate_counter.sv
module freq_gate_counter
  import fcnt_pkg::*;
#(
  parameter int BASE_DIV    = 100,
  parameter int NUM_RANGES  = 4,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int RW         = sel_width(NUM_RANGES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sig_in,
  input  logic [RW-1:0]    range_sel,
  input  logic             run_cont,
  input  logic             start,
  output logic [CNT_W-1:0] result_o,
  output logic [RW-1:0]    range_code_o,
  output logic             overflow_o,
  output logic             result_valid_o
);

  logic                  sig_rise;
  logic                  gate_open;
  logic                  gate_clr;
  logic                  gate_close;
  logic [RW-1:0]         range_q;
  logic [NUM_RANGES-1:0] tick_vec;
  logic [CNT_W-1:0]      acc_cnt;
  logic [CNT_W-1:0]      acc_sum;
  logic                  acc_ovf;

  fcnt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (sig_in),
    .rise_o   (sig_rise)
  );

  fcnt_timebase #(.BASE_DIV(BASE_DIV), .NUM_RANGES(NUM_RANGES)) u_tb (
    .clk    (clk),
    .rst    (rst),
    .clr    (gate_clr),
    .run    (gate_open),
    .tick_o (tick_vec)
  );

  fcnt_gate_fsm #(.NUM_RANGES(NUM_RANGES), .RW(RW)) u_gate (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .run_cont   (run_cont),
    .range_sel  (range_sel),
    .tick_vec   (tick_vec),
    .gate_open  (gate_open),
    .gate_clr   (gate_clr),
    .gate_close (gate_close),
    .range_q    (range_q)
  );

  fcnt_accum #(.CNT_W(CNT_W)) u_acc (
    .clk   (clk),
    .rst   (rst),
    .clr   (gate_clr),
    .en    (gate_open),
    .pulse (sig_rise),
    .cnt_q (acc_cnt),
    .sum_o (acc_sum),
    .ovf_o (acc_ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o       <= '0;
      range_code_o   <= '0;
      overflow_o     <= 1'b0;
      result_valid_o <= 1'b0;
    end else if (gate_close) begin
      result_o       <= acc_sum;
      range_code_o   <= range_q;
      overflow_o     <= acc_ovf;
      result_valid_o <= 1'b1;
    end
  end

endmodule

// File: rtl/fcnt_checker.sv
module fcnt_checker #(
  parameter int CNT_W = 16,
  parameter int RW    = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             gate_open,
  input logic             gate_close,
  input logic             gate_clr,
  input logic [CNT_W-1:0] acc_cnt,
  input logic [RW-1:0]    range_q,
  input logic [CNT_W-1:0] result,
  input logic             valid,
  input logic             ovf
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  p_range_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (gate_open && !gate_clr) |=> $stable(range_q));

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    ovf |-> (result == CNT_MAX));

  p_open_until_tick_r5: assert property (@(posedge clk) disable iff (rst)
    (gate_open && !gate_close) |=> gate_open);

  p_hold_result_r7: assert property (@(posedge clk) disable iff (rst)
    !gate_close |=> ($stable(result) && $stable(ovf)));

  p_valid_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    valid |=> valid);

  p_clear_start_r8: assert property (@(posedge clk) disable iff (rst)
    gate_clr |=> (acc_cnt == '0));

endmodule

bind freq_gate_counter fcnt_checker #(.CNT_W(CNT_W), .RW(RW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .gate_open  (gate_open),
  .gate_close (gate_close),
  .gate_clr   (gate_clr),
  .acc_cnt    (acc_cnt),
  .range_q    (range_q),
  .result     (result_o),
  .valid      (result_valid_o),
  .ovf        (overflow_o)
);

// File: tb/freq_gate_counter_tb.sv
module freq_gate_counter_tb;

  localparam int CLK_PERIOD = 10;
  localparam int BASE_DIV   = 10;
  localparam int NUM_RANGES = 4;
  localparam int CNT_W      = 8;
  localparam int RW         = 2;
  localparam int SEED       = 1234;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             sig_in = 1'b0;
  logic [RW-1:0]    range_sel = '0;
  logic             run_cont = 1'b0;
  logic             start = 1'b0;
  logic [CNT_W-1:0] result_o;
  logic [RW-1:0]    range_code_o;
  logic             overflow_o;
  logic             result_valid_o;

  int checks = 0;
  int errors = 0;
  int half = 0;
  logic hold_val = 1'b0;
  int ph = 0;

  freq_gate_counter #(
    .BASE_DIV(BASE_DIV), .NUM_RANGES(NUM_RANGES), .CNT_W(CNT_W)
  ) u_dut (
    .clk(clk), .rst(rst), .sig_in(sig_in), .range_sel(range_sel),
    .run_cont(run_cont), .start(start), .result_o(result_o),
    .range_code_o(range_code_o), .overflow_o(overflow_o),
    .result_valid_o(result_valid_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // input generator: square wave of period 2*half, or a constant level
  always @(negedge clk) begin
    if (half == 0) begin
      sig_in = hold_val;
      ph = 0;
    end else begin
      ph++;
      if (ph >= half) begin
        ph = 0;
        sig_in = ~sig_in;
      end
    end
  end

  function automatic int gate_len(input int k);
    int g = BASE_DIV;
    for (int i = 0; i < k; i++) g = g * 10;
    return g;
  endfunction

  function automatic bit in_window(input longint act, input int g, input int p);
    longint d = act * p - g;
    if (d < 0) d = -d;
    return d <= p;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_win(input string req, input int g, input int p);
    chk(in_window(longint'(result_o), g, p), req, longint'(result_o), longint'(g / p));
  endtask

  task automatic set_input(input int h, input logic lvl);
    half = h;
    hold_val = lvl;
    repeat (2 * h + 8) @(negedge clk);
  endtask

  // single gate: pulse start, wait until the result edge E0+G has passed
  task automatic measure(input int k);
    range_sel = RW'(k);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (gate_len(k)) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int k, h, g, p;
    logic [CNT_W-1:0] held;
    void'($urandom(SEED));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk(result_o == 0, "R1 result", result_o, 0);
    chk(result_valid_o == 0, "R1 valid", result_valid_o, 0);
    chk(overflow_o == 0, "R1 overflow", overflow_o, 0);
    chk(range_code_o == 0, "R1 code", range_code_o, 0);

    // R3 constant low and constant high both count 0
    set_input(0, 1'b0);
    measure(1);
    chk(result_o == 0, "R3 low level", result_o, 0);
    chk(result_valid_o == 1, "R7 valid set", result_valid_o, 1);
    set_input(0, 1'b1);
    measure(1);
    chk(result_o == 0, "R3 high level", result_o, 0);

    // R2 exact gate timing, code 1 (100 cycles), period 10
    set_input(5, 1'b0);
    range_sel = 2'd1;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (gate_len(1) - 1) @(negedge clk);
    chk(result_o == 0, "R2 not before G", result_o, 0);
    @(negedge clk);
    chk_win("R2 result at G", 100, 10);
    chk(range_code_o == 1, "R2 code", range_code_o, 1);

    // R2 range change mid-gate is ignored
    set_input(2, 1'b0);
    range_sel = 2'd0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) begin start = 1'b0; range_sel = 2'd2; end
    repeat (gate_len(0)) @(negedge clk);
    chk(range_code_o == 0, "R2 captured code", range_code_o, 0);
    chk_win("R2 captured length", 10, 4);

    // R3 random periods and ranges
    for (int i = 0; i < 12; i++) begin
      k = $urandom % 3;
      h = 2 + ($urandom % 19);
      p = 2 * h;
      set_input(h, 1'b0);
      measure(k);
      chk_win("R3 random count", gate_len(k), p);
      chk(range_code_o == RW'(k), "R2 random code", range_code_o, k);
    end

    // R5 start during an open gate is ignored
    set_input(0, 1'b0);
    measure(0);
    chk(result_o == 0, "R5 zero baseline", result_o, 0);
    set_input(4, 1'b0);
    range_sel = 2'd2;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (500) @(negedge clk);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (gate_len(2) - 1 - 501) @(negedge clk);
    chk(result_o == 0, "R5 no early result", result_o, 0);
    @(negedge clk);
    chk_win("R5 result at original G", 1000, 8);
    held = result_o;
    set_input(3, 1'b0);
    repeat (2000) @(negedge clk);
    chk(result_o == held, "R7 hold while idle", result_o, held);

    // R4 overflow: period 2 over 1000 cycles = 500 edges > 255
    set_input(1, 1'b0);
    measure(2);
    chk(result_o == 255, "R4 saturated", result_o, 255);
    chk(overflow_o == 1, "R4 flag", overflow_o, 1);

    // R8 clear at next gate
    set_input(10, 1'b0);
    measure(1);
    chk_win("R8 no carry", 100, 20);
    chk(overflow_o == 0, "R8 overflow cleared", overflow_o, 0);

    // R6 continuous back-to-back gates
    set_input(5, 1'b0);
    range_sel = 2'd1;
    run_cont = 1'b1;
    repeat (3 * 100) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      repeat (37) @(negedge clk);
      chk_win("R6 continuous", 100, 10);
    end
    half = 25;
    repeat (3 * 100 + 60) @(negedge clk);
    chk_win("R6 refresh", 100, 50);
    run_cont = 1'b0;
    repeat (150) @(negedge clk);

    // R3 longest gate: 10000 cycles, period 200
    set_input(100, 1'b0);
    measure(3);
    chk_win("R3 long gate", 10000, 200);
    chk(range_code_o == 3, "R2 top code", range_code_o, 3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule